// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block serves the transmit side of a network controller. Software builds a ring of 8-byte descriptors in host memory and then pulses `kick`. The block walks the ring from its current index. Each descriptor has two words. The first is the byte address of a fragment buffer. The second packs a 16-bit flags field in the upper half and a 16-bit length field in the lower half. The length field holds the fragment byte count minus one. The fragments of each valid descriptor are gathered into a local frame buffer at a running offset. When a descriptor carries the last-fragment flag, the assembled frame leaves on a byte stream. The stream marks the first byte with a start flag and the final byte with an end flag.

Every descriptor the block consumes is written back through the same memory port. In the write-back, the ownership flag and the six error flags are cleared and the length is raised by five. A walk ends after the first completed frame, at the first descriptor not owned by the hardware, or after one full lap of the ring. A walk that sent a frame ends with a one-cycle interrupt pulse. The neighbouring status logic latches this pulse as transmit status bit 4.

Memory access uses a simple word-wide master port. `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` held steady, until the cycle in which `mem_ack` is high. Read data is taken in that same cycle. The frame stream is valid/ready. A beat transfers on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the data and markers are frozen and `tx_valid` does not drop. Downstream may hold `tx_ready` low for any length of time, and the walk simply waits.

Top module: `tx_ring_gatherer`

## Requirements
- R1: After reset, `idle` is high, and `mem_req`, `tx_valid`, `tx_done_irq` and `frag_ovf_err` are all low.
- R2: A `kick` seen while idle starts a walk. `idle` is low from the next cycle until the walk ends and is high again afterwards. Descriptor `i` sits at `ring_base + 8*i`: word 0 is the buffer address, and word 1 holds flags in bits 31:16 and length in bits 15:0.
- R3: A descriptor whose flags bit 15 (owned-by-hardware) is clear ends the walk. That descriptor is not written back and the index does not move.
- R4: A valid descriptor's fragment is length+1 bytes. It is read word by word from a word-aligned buffer, with the low two address bits ignored, and its bytes are taken little-endian (byte 0 in bits 7:0). They are appended to the frame at the current offset.
- R5: A valid descriptor with flags bit 0 (last fragment) causes all gathered bytes to be emitted on the stream in order. `tx_sof` marks the first byte and `tx_eof` the final one. The offset then returns to zero, and the walk ends after this descriptor's write-back.
- R6: Each valid descriptor is written back to word 1 only. The flags field has bits 15, 14, 10, 9, 8, 4 and 3 cleared and all other bits kept. The length field is the original plus 5, modulo 2^16.
- R7: The ring holds `ring_size_m1`+1 entries. The index goes back to 0 after the last entry. At most one full lap of descriptors is consumed per kick. A frame left unfinished when a walk ends keeps its bytes for the next kick.
- R8: If the stored index is beyond the ring at the time of a kick (after the ring was shrunk), the walk starts at index 0.
- R9: `tx_done_irq` pulses for exactly one cycle at the end of a walk that sent a frame, and the block is idle on the following cycle. Walks that sent no frame produce no pulse.
- R10: If a fragment would take the frame past `BUF_BYTES`, the gathered bytes are discarded, the offset resets to zero, and `frag_ovf_err` pulses for one cycle. The descriptor is still written back, and no frame is emitted for it.
- R11: A `rings_reset` pulse while idle sets both the ring index and the gather offset to zero. If it arrives together with `kick`, the walk starts from index 0 with an empty frame.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sof` and `tx_eof` hold their values into the next cycle.
- R13: While `mem_req` is high and `mem_ack` is low, the request and its address, direction and write data hold their values into the next cycle. Every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick | input | 1 | Start a ring walk (used while idle) |
| rings_reset | input | 1 | Zero ring index and gather offset (used while idle) |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_size_m1 | input | IDX_W | Ring entry count minus one |
| idle | output | 1 | High when no walk is in progress |
| tx_done_irq | output | 1 | One-cycle pulse: a walk sent a frame |
| frag_ovf_err | output | 1 | One-cycle pulse: a fragment overflowed the frame buffer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Final byte of a frame |

## Verification
The bench instantiates the block with `BUF_BYTES` = 48 and the default 16-bit index. A 40-byte fragment followed by a 16-byte one is therefore enough to reach the overflow path. Rings of four and eight entries keep wrap-around, a full-lap walk with no frame, and the restart after shrinking the ring to only a few descriptors. The memory responder's latency and the downstream ready pattern vary cycle by cycle, so every hold rule is exercised while requests and beats are actually stalled.

// File: rtl/tgr_pkg.sv
package tgr_pkg;

  localparam int FLG_OWN  = 15;
  localparam int FLG_LAST = 0;

  // ownership plus retry, deferred, carrier, late collision, underflow, error
  localparam logic [15:0] WB_CLEAR_MASK = 16'hC718;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_CTRL,
    ST_CHECK,
    ST_FETCH,
    ST_SEND,
    ST_WB,
    ST_DONE
  } tgr_state_e;

  function automatic logic [31:0] wb_word(input logic [15:0] flags,
                                          input logic [15:0] len);
    return {flags & ~WB_CLEAR_MASK, len + 16'd5};
  endfunction

endpackage

// File: rtl/tgr_ring_index.sv
module tgr_ring_index #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             adv,
  input  logic [IDX_W-1:0] size_m1,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (clr) begin
      idx <= '0;
    end else if (start && (idx > size_m1)) begin
      idx <= '0;
    end else if (adv) begin
      idx <= (idx >= size_m1) ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/tgr_frame_buf.sv
module tgr_frame_buf #(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AIW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [PW-1:0]      waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [CNTW-1:0]    wcnt,
  input  logic [AIW-1:0]     raddr,
  output logic [7:0]         rdata
);

  logic [7:0] bytes_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < LANES; k++) begin
        if ((k < int'(wcnt)) && (int'(waddr) + k < DEPTH)) begin
          bytes_q[AIW'(int'(waddr) + k)] <= wdata[8*k +: 8];
        end
      end
    end
  end

  assign rdata = bytes_q[raddr];

endmodule

// File: rtl/tx_ring_gatherer.sv
module tx_ring_gatherer
  import tgr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDX_W     = 16,
  parameter int BUF_BYTES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             rings_reset,
  input  logic [AW-1:0]    ring_base,
  input  logic [IDX_W-1:0] ring_size_m1,
  output logic             idle,
  output logic             tx_done_irq,
  output logic             frag_ovf_err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_sof,
  output logic             tx_eof
);

  localparam int LANES = 4;
  localparam int OW    = $clog2(BUF_BYTES + 1);
  localparam int AIW   = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
  localparam int CW    = ((OW > 17) ? OW : 17) + 1;

  tgr_state_e       state;
  logic [AW-3:0]    fptr;
  logic [15:0]      d_len;
  logic [15:0]      d_flags;
  logic [OW-1:0]    offset;
  logic [16:0]      remain;
  logic [OW-1:0]    sptr;
  logic [IDX_W:0]   seen;
  logic             sent;

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    desc_addr;
  logic [16:0]      need;
  logic             ovf;
  logic [2:0]       chunk;
  logic [IDX_W:0]   ring_len;
  logic             in_idle;
  logic             idx_adv;
  logic             buf_we;
  logic [7:0]       buf_byte;

  assign in_idle   = (state == ST_IDLE);
  assign desc_addr = ring_base + (AW'(idx) << 3);
  assign need      = {1'b0, d_len} + 17'd1;
  assign ovf       = (CW'(offset) + CW'(need)) > CW'(BUF_BYTES);
  assign chunk     = (remain > 17'd4) ? 3'd4 : remain[2:0];
  assign ring_len  = {1'b0, ring_size_m1} + 1'b1;
  assign idx_adv   = (state == ST_WB) && mem_ack;
  assign buf_we    = (state == ST_FETCH) && mem_ack;

  tgr_ring_index #(.IDX_W(IDX_W)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (in_idle && rings_reset),
    .start   (in_idle && kick),
    .adv     (idx_adv),
    .size_m1 (ring_size_m1),
    .idx     (idx)
  );

  tgr_frame_buf #(.DEPTH(BUF_BYTES), .LANES(LANES)) u_fbuf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (offset),
    .wdata (mem_rdata),
    .wcnt  (chunk),
    .raddr (sptr[AIW-1:0]),
    .rdata (buf_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fptr    <= '0;
      d_len   <= '0;
      d_flags <= '0;
      offset  <= '0;
      remain  <= '0;
      sptr    <= '0;
      seen    <= '0;
      sent    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rings_reset) offset <= '0;
          if (kick) begin
            seen  <= '0;
            sent  <= 1'b0;
            state <= ST_RD_ADDR;
          end
        end
        ST_RD_ADDR: begin
          if (mem_ack) begin
            fptr  <= mem_rdata[AW-1:2];
            state <= ST_RD_CTRL;
          end
        end
        ST_RD_CTRL: begin
          if (mem_ack) begin
            d_len   <= mem_rdata[15:0];
            d_flags <= mem_rdata[31:16];
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!d_flags[FLG_OWN]) begin
            state <= ST_DONE;
          end else begin
            seen <= seen + 1'b1;
            if (ovf) begin
              offset <= '0;
              state  <= ST_WB;
            end else begin
              remain <= need;
              state  <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            offset <= offset + OW'(chunk);
            remain <= remain - 17'(chunk);
            fptr   <= fptr + 1'b1;
            if (remain <= 17'd4) begin
              sptr  <= '0;
              state <= d_flags[FLG_LAST] ? ST_SEND : ST_WB;
            end
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (tx_eof) begin
              offset <= '0;
              sent   <= 1'b1;
              state  <= ST_WB;
            end else begin
              sptr <= sptr + 1'b1;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            if (d_flags[FLG_LAST] || (seen == ring_len)) state <= ST_DONE;
            else                                          state <= ST_RD_ADDR;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    unique case (state)
      ST_RD_ADDR: mem_req = 1'b1;
      ST_RD_CTRL: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = {fptr, 2'b00};
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(4);
        mem_wdata = wb_word(d_flags, d_len);
      end
      default: ;
    endcase
  end

  assign idle         = in_idle;
  assign tx_done_irq  = (state == ST_DONE) && sent;
  assign frag_ovf_err = (state == ST_CHECK) && d_flags[FLG_OWN] && ovf;
  assign tx_valid     = (state == ST_SEND);
  assign tx_data      = buf_byte;
  assign tx_sof       = (sptr == '0);
  assign tx_eof       = (sptr == offset - 1'b1);

endmodule

// File: rtl/tgr_checker.sv
module tgr_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle,
  input logic          tx_done_irq,
  input logic          frag_ovf_err,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_sof,
  input logic          tx_eof
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R13

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req && !tx_valid); // R2

  AST_WB_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_wdata[31:16] & 16'hC718) == 16'h0000); // R6

  AST_IRQ_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_irq |=> idle && !tx_done_irq); // R9

  AST_OVF_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    frag_ovf_err |-> !tx_valid && !tx_done_irq && !idle); // R10

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frag_ovf_err |=> !frag_ovf_err); // R10

endmodule

bind tx_ring_gatherer tgr_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .idle         (idle),
  .tx_done_irq  (tx_done_irq),
  .frag_ovf_err (frag_ovf_err),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_sof       (tx_sof),
  .tx_eof       (tx_eof)
);

// File: tb/tx_ring_gatherer_test.sv
module tx_ring_gatherer_test;

  localparam int AW    = 32;
  localparam int IDX_W = 16;
  localparam int BUFB  = 48;
  localparam int BASE  = 32'h100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             kick = 1'b0;
  logic             rings_reset = 1'b0;
  logic [IDX_W-1:0] rsz_m1 = 16'd3;
  logic             idle, tx_done_irq, frag_ovf_err;
  logic             mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_wdata, mem_rdata = '0;
  logic             tx_valid, tx_ready = 1'b1;
  logic [7:0]       tx_data;
  logic             tx_sof, tx_eof;

  tx_ring_gatherer #(.AW(AW), .IDX_W(IDX_W), .BUF_BYTES(BUFB)) uut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .rings_reset(rings_reset),
    .ring_base(AW'(BASE)), .ring_size_m1(rsz_m1),
    .idle(idle), .tx_done_irq(tx_done_irq), .frag_ovf_err(frag_ovf_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:1023];
  logic [7:0]  m_part [$];
  logic [9:0]  exp_stream [$];
  logic [63:0] exp_wr [$];
  int          m_idx = 0;
  int          irq_exp = 0, irq_seen = 0;
  int          err_exp = 0, err_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          lat = 0;
  bit          bp_on = 1'b0;
  logic [9:0]  beat_e;
  logic [63:0] wr_e;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and stream sink, driven and sampled at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = bp_on ? lfsr[0] : 1'b1;
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (rst_n && mem_req) begin
      if (lat == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          if (exp_wr.size() == 0) check(1'b0, "R6", {mem_addr, mem_wdata}, 64'h0);
          else begin
            wr_e = exp_wr.pop_front();
            check({mem_addr, mem_wdata} == wr_e, "R6", {mem_addr, mem_wdata}, wr_e);
          end
          mem[mem_addr[11:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
        end
        lat = int'(lfsr[3:2]) & (bp_on ? 3 : 1);
      end else begin
        lat--;
      end
    end
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_stream.size() == 0) check(1'b0, "R5", {tx_sof, tx_eof, tx_data}, 64'h0);
      else begin
        beat_e = exp_stream.pop_front();
        check({tx_sof, tx_eof, tx_data} == beat_e, "R5", {tx_sof, tx_eof, tx_data}, beat_e);
      end
    end
    if (rst_n && tx_done_irq) irq_seen++;
    if (rst_n && frag_ovf_err) err_seen++;
  end

  task automatic set_desc(input int i, input int len, input logic [15:0] flags);
    int a = BASE + i * 8;
    mem[a / 4]     = 32'h800 + 32'(i) * 32'h40;
    mem[a / 4 + 1] = {flags, 16'(len)};
  endtask

  // behavioural model of one walk, computed from memory before the kick
  task automatic model_walk();
    int n = int'(rsz_m1) + 1;
    if (m_idx >= n) m_idx = 0;
    for (int i = 0; i < n; i++) begin
      int a = BASE + m_idx * 8;
      logic [31:0] w0 = mem[a / 4];
      logic [31:0] w1 = mem[a / 4 + 1];
      logic [15:0] len = w1[15:0];
      logic [15:0] fl = w1[31:16];
      int cnt = int'(len) + 1;
      bit ov;
      if (!fl[15]) break;
      m_idx = (m_idx + 1) % n;
      ov = (m_part.size() + cnt > BUFB);
      if (ov) begin
        m_part.delete();
        err_exp++;
      end else begin
        for (int k = 0; k < cnt; k++) begin
          logic [31:0] w = mem[int'(w0[11:2]) + k / 4];
          m_part.push_back(w[8 * (k % 4) +: 8]);
        end
      end
      if (fl[0] && !ov) begin
        for (int k = 0; k < m_part.size(); k++)
          exp_stream.push_back({k == 0, k == m_part.size() - 1, m_part[k]});
        m_part.delete();
        irq_exp++;
      end
      exp_wr.push_back({32'(a + 4), fl & ~16'hC718, len + 16'd5});
      if (fl[0]) break;
    end
  endtask

  task automatic walk(input string tag);
    int guard = 0;
    model_walk();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    check(idle == 1'b0, "R2", 64'(idle), 64'h0);
    while (!idle && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    check(idle == 1'b1, "R2", 64'(idle), 64'h1);
    check(exp_stream.size() == 0, "R5", 64'(exp_stream.size()), 64'h0);
    check(exp_wr.size() == 0, "R3", 64'(exp_wr.size()), 64'h0);
    check(irq_seen == irq_exp, "R9", 64'(irq_seen), 64'(irq_exp));
    check(err_seen == err_exp, "R10", 64'(err_seen), 64'(err_exp));
    $display("walk %s done", tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = {8'(i) ^ 8'h5A, 8'(i * 3), 8'(i + 7), 8'(i * 5) ^ 8'hC3};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(idle == 1'b1, "R1", 64'(idle), 64'h1);
    check(mem_req == 1'b0 && tx_valid == 1'b0, "R1", {mem_req, tx_valid}, 64'h0);
    check(tx_done_irq == 1'b0 && frag_ovf_err == 1'b0, "R1", {tx_done_irq, frag_ovf_err}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R6: single 10-byte frame
    set_desc(0, 9, 16'h8001);
    walk("single");

    // R4 R6 R12: three fragments, error flags set, back-pressure
    bp_on = 1'b1;
    set_desc(1, 4, 16'h8000);
    set_desc(2, 0, 16'h8006);
    set_desc(3, 6, 16'hFFFF);
    walk("gather");

    // R3 R7: wrap to entry 0, stop at unowned entry, partial frame kept
    set_desc(0, 2, 16'h8000);
    set_desc(1, 0, 16'h0001);
    walk("stop");
    set_desc(1, 3, 16'h8001);
    walk("resume");

    // R7: full lap with no last flag, no frame, no pulse
    for (int i = 0; i < 4; i++) set_desc(i, 0, 16'h8000);
    walk("lap");

    // R11: rings_reset clears index and offset
    @(negedge clk); rings_reset = 1'b1;
    @(negedge clk); rings_reset = 1'b0;
    m_idx = 0;
    m_part.delete();
    set_desc(0, 1, 16'h8001);
    set_desc(1, 0, 16'h0000);
    walk("after_reset");

    // R10: overflow discards the frame
    set_desc(1, 39, 16'h8000);
    set_desc(2, 15, 16'h8001);
    walk("overflow");
    set_desc(3, 0, 16'h8001);
    walk("post_overflow");

    // R8: shrink the ring while the index is beyond it
    bp_on = 1'b0;
    rsz_m1 = 16'd7;
    for (int i = 0; i < 5; i++) set_desc(i, 0, 16'h8000);
    set_desc(5, 0, 16'h0000);
    walk("long_ring");
    rsz_m1 = 16'd3;
    set_desc(0, 2, 16'h8001);
    walk("shrunk");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule